// File: doc/BRIEF.md
# SPI Slave with Armed-Operation Detection

This block is the target end of a four-wire synchronous serial link. An external master drives the serial clock, the select line and the master-to-slave data line. The block samples all three with the system clock and drives the slave-to-master data line together with an output enable for the pad. Because every pin input passes through a synchronizer first, the serial clock must run at no more than one quarter of the system clock.

The local side arms a counted operation before the master clocks anything. The operation is send-only, receive-only or full duplex, and it carries an item count. Outgoing words are read from a holding input, and a pop strobe tells the local side when a word has been consumed. Incoming words appear on a data output with a one-cycle valid strobe. When the master shifts a whole frame while nothing is armed, the block raises a data-lost event, which shows that the local side fell behind.

The following settings are chosen by configuration inputs:
- clock polarity and phase;
- frame length, from 1 to 32 bits;
- bit order;
- select policy: the hardware select pin, or a local enable bit that stands in for a missing pin.

Top module: `spi_armed_slave`

## Requirements
- R1: After reset, `busy`, `item_count`, `evt`, `rx_valid` and `miso_oe` are all zero.
- R2: With the hardware policy (`cfg_ss_soft`=0), bits are taken only while `ss_n` is low. Clock edges seen while `ss_n` is high change no count and raise no event.
- R3: With the software policy (`cfg_ss_soft`=1), `ss_n` is ignored and the block responds only while `soft_sel` is 1. After reset `soft_sel` is 0, so the block does not respond.
- R4: A frame that completes while no operation is armed raises `evt` bit 1 (data lost) for one cycle and gives no `rx_valid`.
- R5: An armed operation stays `busy` with `item_count`=0 until the master shifts frames.
- R6: When `item_count` reaches the armed count, `evt` bit 0 (complete) pulses, `busy` falls, and the block accepts a new arm.
- R7: In a receive-only operation (`arm_op`=2'b10), MISO carries `dflt_tx`, and each item gives one `rx_valid` carrying the received word.
- R8: In a send-only operation (`arm_op`=2'b01), MISO carries `tx_data`, `tx_pop` pulses once per completed item, and no `rx_valid` occurs.
- R9: All four polarity/phase modes work. Data is sampled on the leading edge when phase is 0 and on the trailing edge when phase is 1. The leading edge is the rising edge when polarity is 0.
- R10: The frame length is `cfg_len_m1`+1 bits. `cfg_lsb_first`=0 sends bit `cfg_len_m1` first and `cfg_lsb_first`=1 sends bit 0 first. Received words are right-aligned.
- R11: When phase is 0, the first MISO bit is valid once select becomes active, before any clock edge.
- R12: Deselecting in the middle of a frame discards the partial frame. The next selection starts a fresh frame with the same outgoing word.
- R13: While the block is not selected, `miso_oe` and `miso` are 0.
- R14: An arm request is ignored while `busy` is high, when `arm_op` is 2'b00, or when `arm_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Data from the master |
| ss_n | input | 1 | Active-low select from the master |
| miso | output | 1 | Data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_len_m1 | input | 5 | Frame length minus one |
| cfg_ss_soft | input | 1 | 1 selects the software select policy |
| soft_sel | input | 1 | Local enable used in the software policy |
| dflt_tx | input | 32 | Word shifted out when there is nothing to send |
| arm | input | 1 | Arm request strobe |
| arm_op | input | 2 | 01 send, 10 receive, 11 duplex |
| arm_count | input | 16 | Number of items in the operation |
| tx_data | input | 32 | Holding word to transmit |
| tx_pop | output | 1 | A transmitted word has been consumed |
| rx_data | output | 32 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | An operation is armed |
| item_count | output | 16 | Items completed in the current operation |
| evt | output | 2 | Event pulses: bit 0 complete, bit 1 data lost |

## Verification
The hardest case to reach is a frame that must have no effect. This covers clocking while the select pin is high, clocking under the software policy before the enable is set, and a frame cut short by deselection. The stimulus keeps an operation armed while the master clocks complete frames into each of these conditions. It then checks that `busy` stays high and that `item_count`, the data-lost count and the valid count are unchanged. Finally it runs a clean frame and shows that this frame, and only this one, completes the operation with the original outgoing word.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SEND = 2'b01,
    OP_RECV = 2'b10,
    OP_XFER = 2'b11
  } op_e;

  localparam int SYNC_STAGES = 2;

  function automatic logic op_sends(op_e o);
    return (o == OP_SEND) || (o == OP_XFER);
  endfunction

  function automatic logic op_recvs(op_e o);
    return (o == OP_RECV) || (o == OP_XFER);
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q, stg_n;

  always_comb begin
    stg_n[0] = d;
    for (int i = 1; i < STAGES; i++) stg_n[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_slv_front.sv
module spi_slv_front import spi_slv_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic mosi,
  input  logic ss_n,
  input  logic cpol,
  input  logic cpha,
  input  logic ss_soft,
  input  logic soft_sel,
  output logic sel,
  output logic sel_rise,
  output logic samp_ev,
  output logic shift_ev,
  output logic mosi_s
);

  logic ss_s, sclk_s;
  logic sclk_q, sel_q;
  logic rise, fall, lead, trail;

  spi_slv_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ss_n, mosi, sclk}),
    .q     ({ss_s, mosi_s, sclk_s})
  );

  // selection policy: pin or local enable
  assign sel      = ss_soft ? soft_sel : ~ss_s;
  assign sel_rise = sel & ~sel_q;

  assign rise  = sclk_s & ~sclk_q;
  assign fall  = ~sclk_s & sclk_q;
  assign lead  = cpol ? fall : rise;
  assign trail = cpol ? rise : fall;

  assign samp_ev  = sel & (cpha ? trail : lead);
  assign shift_ev = sel & (cpha ? lead : trail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel;
    end
  end

  a_r9_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(samp_ev && shift_ev));

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift #(
  parameter int DW = 32,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sel_rise,
  input  logic          samp_ev,
  input  logic          shift_ev,
  input  logic          mosi_s,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic [LW-1:0] len_m1,
  input  logic [DW-1:0] tx_word,
  output logic          frame_done,
  output logic [DW-1:0] rx_word,
  output logic          miso_bit
);

  logic [LW-1:0] bit_cnt_q, bit_cnt_n;
  logic [LW-1:0] tx_idx_q, tx_idx_n;
  logic [DW-1:0] txw_q, txw_n;
  logic [DW-1:0] rx_sh_q, rx_sh_n;
  logic [LW-1:0] rx_pos, tx_pos;
  logic          load;

  assign rx_pos     = lsb_first ? bit_cnt_q : (len_m1 - bit_cnt_q);
  assign tx_pos     = lsb_first ? tx_idx_q  : (len_m1 - tx_idx_q);
  assign frame_done = samp_ev && (bit_cnt_q == len_m1);
  assign rx_word    = ((bit_cnt_q == '0) ? '0 : rx_sh_q)
                    | ({{(DW-1){1'b0}}, mosi_s} << rx_pos);
  // word load at frame start: on select (phase 0) or on first shift edge
  assign load       = (sel_rise & ~cpha) | (shift_ev & (bit_cnt_q == '0));
  assign miso_bit   = txw_q[tx_pos];

  always_comb begin
    bit_cnt_n = bit_cnt_q;
    tx_idx_n  = tx_idx_q;
    txw_n     = txw_q;
    rx_sh_n   = rx_sh_q;
    if (!sel) begin
      bit_cnt_n = '0;
      tx_idx_n  = '0;
    end else begin
      if (samp_ev) begin
        rx_sh_n   = rx_word;
        bit_cnt_n = frame_done ? '0 : bit_cnt_q + 1'b1;
      end
      if (load) begin
        txw_n    = tx_word;
        tx_idx_n = '0;
      end else if (shift_ev) begin
        tx_idx_n = tx_idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      tx_idx_q  <= '0;
      txw_q     <= '0;
      rx_sh_q   <= '0;
    end else begin
      bit_cnt_q <= bit_cnt_n;
      tx_idx_q  <= tx_idx_n;
      txw_q     <= txw_n;
      rx_sh_q   <= rx_sh_n;
    end
  end

  a_r12_partial_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (bit_cnt_q == '0));

  a_r10_count_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (bit_cnt_q <= len_m1));

endmodule

// File: rtl/spi_slv_opctl.sv
module spi_slv_opctl import spi_slv_pkg::*; #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [1:0]    arm_op,
  input  logic [CW-1:0] arm_count,
  input  logic          frame_done,
  input  logic [DW-1:0] rx_word,
  input  logic [DW-1:0] tx_data,
  input  logic [DW-1:0] dflt_tx,
  output logic [DW-1:0] tx_word,
  output logic          tx_pop,
  output logic          busy,
  output logic [CW-1:0] item_count,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic [1:0]    evt
);

  logic          busy_q, busy_n;
  op_e           op_q, op_n;
  logic [CW-1:0] tgt_q, tgt_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_inc;
  logic          rxv_q, rxv_n;
  logic [DW-1:0] rxd_q, rxd_n;
  logic [1:0]    evt_q, evt_n;
  logic          arm_ok;

  assign arm_ok  = arm & ~busy_q & (arm_op != 2'b00) & (arm_count != '0);
  assign cnt_inc = cnt_q + 1'b1;
  assign tx_word = (busy_q && op_sends(op_q)) ? tx_data : dflt_tx;
  assign tx_pop  = frame_done & busy_q & op_sends(op_q);

  always_comb begin
    busy_n = busy_q;
    op_n   = op_q;
    tgt_n  = tgt_q;
    cnt_n  = cnt_q;
    rxd_n  = rxd_q;
    rxv_n  = 1'b0;
    evt_n  = 2'b00;
    if (frame_done) begin
      if (busy_q) begin
        cnt_n = cnt_inc;
        if (op_recvs(op_q)) begin
          rxv_n = 1'b1;
          rxd_n = rx_word;
        end
        if (cnt_inc == tgt_q) begin
          busy_n   = 1'b0;
          evt_n[0] = 1'b1;
        end
      end else begin
        evt_n[1] = 1'b1;
      end
    end
    if (arm_ok) begin
      busy_n = 1'b1;
      op_n   = op_e'(arm_op);
      tgt_n  = arm_count;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= OP_NONE;
      tgt_q  <= '0;
      cnt_q  <= '0;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
      evt_q  <= 2'b00;
    end else begin
      busy_q <= busy_n;
      op_q   <= op_n;
      tgt_q  <= tgt_n;
      cnt_q  <= cnt_n;
      rxv_q  <= rxv_n;
      rxd_q  <= rxd_n;
      evt_q  <= evt_n;
    end
  end

  assign busy       = busy_q;
  assign item_count = cnt_q;
  assign rx_valid   = rxv_q;
  assign rx_data    = rxd_q;
  assign evt        = evt_q;

  a_r6_done_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q[0] |-> !busy_q);

  a_r6_count_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < tgt_q));

  a_r14_arm_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));

  a_r7_valid_needs_recv: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> op_recvs(op_q));

endmodule

// File: rtl/spi_armed_slave.sv
module spi_armed_slave #(
  parameter int DW = 32,
  parameter int CW = 16,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          ss_n,
  output logic          miso,
  output logic          miso_oe,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          cfg_lsb_first,
  input  logic [LW-1:0] cfg_len_m1,
  input  logic          cfg_ss_soft,
  input  logic          soft_sel,
  input  logic [DW-1:0] dflt_tx,
  input  logic          arm,
  input  logic [1:0]    arm_op,
  input  logic [CW-1:0] arm_count,
  input  logic [DW-1:0] tx_data,
  output logic          tx_pop,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          busy,
  output logic [CW-1:0] item_count,
  output logic [1:0]    evt
);

  logic          sel, sel_rise, samp_ev, shift_ev, mosi_s;
  logic          frame_done, miso_bit;
  logic [DW-1:0] rx_word, tx_word;

  spi_slv_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .ss_n     (ss_n),
    .cpol     (cfg_cpol),
    .cpha     (cfg_cpha),
    .ss_soft  (cfg_ss_soft),
    .soft_sel (soft_sel),
    .sel      (sel),
    .sel_rise (sel_rise),
    .samp_ev  (samp_ev),
    .shift_ev (shift_ev),
    .mosi_s   (mosi_s)
  );

  spi_slv_shift #(.DW(DW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .sel_rise   (sel_rise),
    .samp_ev    (samp_ev),
    .shift_ev   (shift_ev),
    .mosi_s     (mosi_s),
    .cpha       (cfg_cpha),
    .lsb_first  (cfg_lsb_first),
    .len_m1     (cfg_len_m1),
    .tx_word    (tx_word),
    .frame_done (frame_done),
    .rx_word    (rx_word),
    .miso_bit   (miso_bit)
  );

  spi_slv_opctl #(.DW(DW), .CW(CW)) u_opctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .arm_op     (arm_op),
    .arm_count  (arm_count),
    .frame_done (frame_done),
    .rx_word    (rx_word),
    .tx_data    (tx_data),
    .dflt_tx    (dflt_tx),
    .tx_word    (tx_word),
    .tx_pop     (tx_pop),
    .busy       (busy),
    .item_count (item_count),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .evt        (evt)
  );

  // R13: pad released whenever not selected
  assign miso_oe = sel;
  assign miso    = sel & miso_bit;

endmodule

// File: tb/spi_armed_slave_test.sv
module spi_armed_slave_test;

  localparam int H = 6;

  typedef struct packed {
    logic        cpol;
    logic        cpha;
    logic        lsb;
    logic [4:0]  lm1;
    logic [31:0] tx;
    logic [31:0] mo;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 1'b0, 5'd7,  32'h000000C3, 32'h0000005A},
    '{1'b0, 1'b1, 1'b1, 5'd7,  32'h00000081, 32'h0000003E},
    '{1'b1, 1'b0, 1'b0, 5'd15, 32'h0000BEEF, 32'h00001234},
    '{1'b1, 1'b1, 1'b1, 5'd15, 32'h00008001, 32'h00007FFE},
    '{1'b0, 1'b0, 1'b1, 5'd0,  32'h00000001, 32'h00000001},
    '{1'b1, 1'b1, 1'b0, 5'd31, 32'hDEADBEEF, 32'h0F1E2D3C},
    '{1'b0, 1'b1, 1'b0, 5'd4,  32'h00000015, 32'h0000000A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic        miso, miso_oe;
  logic        cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
  logic [4:0]  lm1 = 5'd7;
  logic        ss_soft = 1'b0, soft_sel = 1'b0;
  logic [31:0] dflt_tx = 32'h000000A5;
  logic        arm = 1'b0;
  logic [1:0]  arm_op = 2'b00;
  logic [15:0] arm_count = '0;
  logic [31:0] tx_data = '0;
  logic        tx_pop, rx_valid, busy;
  logic [31:0] rx_data;
  logic [15:0] item_count;
  logic [1:0]  evt;

  int n_total = 0, n_fail = 0;
  int n_rxv = 0, n_done = 0, n_lost = 0, n_pop = 0;
  logic [31:0] last_rx = '0;
  bit finished = 1'b0;

  spi_armed_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
    .miso(miso), .miso_oe(miso_oe), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_len_m1(lm1), .cfg_ss_soft(ss_soft),
    .soft_sel(soft_sel), .dflt_tx(dflt_tx), .arm(arm), .arm_op(arm_op),
    .arm_count(arm_count), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
    .item_count(item_count), .evt(evt)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin n_rxv++; last_rx = rx_data; end
      if (evt[0]) n_done++;
      if (evt[1]) n_lost++;
      if (tx_pop) n_pop++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input logic [4:0] l);
    logic [63:0] m = (64'd1 << (l + 1)) - 64'd1;
    return m[31:0];
  endfunction

  task automatic do_arm(input logic [1:0] op, input logic [15:0] cnt);
    arm_op = op; arm_count = cnt; arm = 1'b1;
    tick(1);
    arm = 1'b0;
    tick(2);
  endtask

  // bench-side master: shifts nbits of mo, captures MISO into mi
  task automatic xfer(input logic [31:0] mo, input int nbits, output logic [31:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      int idx = lsb ? i : (int'(lm1) - i);
      if (!cpha) begin
        mosi = mo[idx];
        tick(H);
        mi[idx] = miso;
        sclk = ~cpol;
        tick(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        mosi = mo[idx];
        tick(H);
        mi[idx] = miso;
        sclk = cpol;
        tick(H);
      end
    end
    tick(H);
  endtask

  task automatic set_cfg(input logic p, input logic ph, input logic l, input logic [4:0] len);
    cpol = p; cpha = ph; lsb = l; lm1 = len; sclk = p;
    tick(4);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] mi;
    int b_rxv, b_done, b_lost, b_pop;

    tick(3);
    // R1 reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 item_count", {16'd0, item_count}, 32'd0);
    check("R1 evt", {30'd0, evt}, 32'd0);
    check("R1 oe", {31'd0, miso_oe}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    check("R1 rx_valid", {31'd0, rx_valid}, 32'd0);

    // vector table: R9 R10 duplex single item per mode/length/order
    for (int v = 0; v < 7; v++) begin
      set_cfg(VECS[v].cpol, VECS[v].cpha, VECS[v].lsb, VECS[v].lm1);
      tx_data = VECS[v].tx;
      b_rxv = n_rxv; b_done = n_done;
      do_arm(2'b11, 16'd1);
      ss_n = 1'b0; tick(H);
      xfer(VECS[v].mo, int'(VECS[v].lm1) + 1, mi);
      ss_n = 1'b1; tick(8);
      check("R9 R10 miso word", mi & mask(VECS[v].lm1), VECS[v].tx & mask(VECS[v].lm1));
      check("R10 rx word", last_rx, VECS[v].mo & mask(VECS[v].lm1));
      check("R6 done pulse", n_done - b_done, 1);
      check("R7 one valid", n_rxv - b_rxv, 1);
      check("R6 busy low", {31'd0, busy}, 32'd0);
      check("R6 item_count", {16'd0, item_count}, 32'd1);
      check("R13 oe off", {30'd0, miso_oe, miso}, 32'd0);
    end

    set_cfg(1'b0, 1'b0, 1'b0, 5'd7);

    // R4 data lost with nothing armed
    b_rxv = n_rxv; b_lost = n_lost; b_done = n_done;
    ss_n = 1'b0; tick(H);
    xfer(32'h66, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R4 lost event", n_lost - b_lost, 1);
    check("R4 no valid", n_rxv - b_rxv, 0);
    check("R4 no done", n_done - b_done, 0);

    // R5 R14 R6 two-item duplex, arm while busy ignored
    tx_data = 32'h11;
    b_rxv = n_rxv; b_done = n_done; b_pop = n_pop;
    do_arm(2'b11, 16'd2);
    do_arm(2'b10, 16'd1);
    tick(20);
    check("R5 still busy", {31'd0, busy}, 32'd1);
    check("R5 no items", {16'd0, item_count}, 32'd0);
    ss_n = 1'b0; tick(H);
    xfer(32'hAA, 8, mi);
    check("R14 first item not final", {31'd0, busy}, 32'd1);
    check("R14 item count 1", {16'd0, item_count}, 32'd1);
    check("R6 first word out", mi, 32'h11);
    xfer(32'hBB, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R6 second word out", mi, 32'h11);
    check("R6 busy low after 2", {31'd0, busy}, 32'd0);
    check("R6 item count 2", {16'd0, item_count}, 32'd2);
    check("R6 done once", n_done - b_done, 1);
    check("R6 two valids", n_rxv - b_rxv, 2);
    check("R6 last word", last_rx, 32'hBB);
    check("R8 pops duplex", n_pop - b_pop, 2);

    // R14 invalid arms
    do_arm(2'b00, 16'd3);
    check("R14 op none ignored", {31'd0, busy}, 32'd0);
    do_arm(2'b11, 16'd0);
    check("R14 zero count ignored", {31'd0, busy}, 32'd0);

    // R11 phase 0 first bit before any edge, then finish frame
    tx_data = 32'h80;
    do_arm(2'b11, 16'd1);
    check("R6 re-arm accepted", {31'd0, busy}, 32'd1);
    ss_n = 1'b0; tick(H);
    check("R11 oe on select", {31'd0, miso_oe}, 32'd1);
    check("R11 first bit early", {31'd0, miso}, 32'd1);
    xfer(32'h01, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R11 word", mi, 32'h80);

    // R7 receive-only shifts default word
    tx_data = 32'h3C;
    b_rxv = n_rxv; b_pop = n_pop;
    do_arm(2'b10, 16'd1);
    ss_n = 1'b0; tick(H);
    xfer(32'h42, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R7 default out", mi, 32'hA5);
    check("R7 valid", n_rxv - b_rxv, 1);
    check("R7 rx word", last_rx, 32'h42);
    check("R7 no pop", n_pop - b_pop, 0);

    // R8 send-only
    tx_data = 32'h5A;
    b_rxv = n_rxv; b_pop = n_pop; b_done = n_done;
    do_arm(2'b01, 16'd1);
    ss_n = 1'b0; tick(H);
    xfer(32'h99, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R8 word out", mi, 32'h5A);
    check("R8 no valid", n_rxv - b_rxv, 0);
    check("R8 pop", n_pop - b_pop, 1);
    check("R8 done", n_done - b_done, 1);

    // R2 edges with select high are ignored
    tx_data = 32'h3C;
    b_rxv = n_rxv; b_lost = n_lost; b_done = n_done;
    do_arm(2'b11, 16'd1);
    xfer(32'h77, 8, mi);
    tick(8);
    check("R2 busy kept", {31'd0, busy}, 32'd1);
    check("R2 no item", {16'd0, item_count}, 32'd0);
    check("R2 no valid", n_rxv - b_rxv, 0);
    check("R2 no lost", n_lost - b_lost, 0);
    check("R13 oe off unselected", {31'd0, miso_oe}, 32'd0);
    ss_n = 1'b0; tick(H);
    xfer(32'h77, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R2 real frame done", n_done - b_done, 1);
    check("R2 real frame word", last_rx, 32'h77);

    // R3 software policy: pin ignored, enable gates
    ss_soft = 1'b1; tick(4);
    b_rxv = n_rxv; b_done = n_done; b_lost = n_lost;
    do_arm(2'b11, 16'd1);
    ss_n = 1'b0;
    xfer(32'h21, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R3 disabled busy kept", {31'd0, busy}, 32'd1);
    check("R3 disabled no valid", n_rxv - b_rxv, 0);
    check("R3 disabled oe", {31'd0, miso_oe}, 32'd0);
    soft_sel = 1'b1; tick(H);
    xfer(32'h21, 8, mi);
    tick(8);
    check("R3 enabled word out", mi, 32'h3C);
    check("R3 enabled rx", last_rx, 32'h21);
    check("R3 enabled done", n_done - b_done, 1);
    check("R3 no lost", n_lost - b_lost, 0);
    soft_sel = 1'b0; ss_soft = 1'b0; tick(8);

    // R12 mid-frame deselect discards partial frame
    tx_data = 32'hC6;
    b_rxv = n_rxv; b_done = n_done; b_lost = n_lost;
    do_arm(2'b11, 16'd1);
    ss_n = 1'b0; tick(H);
    xfer(32'hFF, 3, mi);
    ss_n = 1'b1; tick(8);
    check("R12 partial no valid", n_rxv - b_rxv, 0);
    check("R12 partial busy", {31'd0, busy}, 32'd1);
    ss_n = 1'b0; tick(H);
    xfer(32'h96, 8, mi);
    ss_n = 1'b1; tick(8);
    check("R12 fresh rx", last_rx, 32'h96);
    check("R12 same tx word", mi, 32'hC6);
    check("R12 done", n_done - b_done, 1);
    check("R12 no lost", n_lost - b_lost, 0);

    finished = 1'b1;
    finish_run();
  end

endmodule